// File: doc/BRIEF.md
# Match-Compare Tick Timer

This block is a memory-mapped tick timer that an operating system uses for its periodic scheduler interrupt. A free-running up-counter advances by one on every timer tick. Ticks come from a `tick_en` qualifier combined with a parameterised prescaler, so that a faster bus clock can yield the nominal 50 MHz count rate. Software loads a match value. When the counter steps onto that value, and the interrupt-enable word is nonzero, a sticky status bit is set and the level interrupt output goes high.

Software acknowledges the interrupt by writing zero to the status word. To set up the next interrupt it writes a new match value. The distance to that match is taken modulo the counter range, so a match value at or below the current count fires only after the counter wraps. The bus is a simple 32-bit slave port that acts only on full-word accesses. Read data is registered and appears one cycle after the request.

Top module: `ostick_timer`

## Requirements
- R1: Reset is synchronous and active high. It clears the counter, the match value, the status bit, the enable word, the read data and `irq` to zero.
- R2: The counter increases by one on each tick and wraps modulo 2^CNT_W. A tick is every PRESCALE-th clock cycle on which `tick_en` is high, counted from reset.
- R3: On a tick that moves the counter onto the match value while the enable word (offset 0x1C) is nonzero, the status bit becomes 1 and `irq` is high from the next clock edge.
- R4: While the enable word is zero, a match leaves the status bit and `irq` unchanged. Enabling afterwards does not raise them retroactively.
- R5: A full-word write of zero to offset 0x14 clears the status bit and `irq`. Nonzero writes to offset 0x14 are ignored.
- R6: When a match event and a status-clear write happen in the same cycle, the status bit stays set.
- R7: A write to offset 0x00 re-arms the compare. The next event occurs after (match − count) mod 2^CNT_W ticks. A match equal to the current count fires after 2^CNT_W ticks.
- R8: A read returns its data on `bus_rdata` one cycle after the request. Offset 0x10 gives the counter, zero-extended. Offset 0x14 gives the status in bit 0. Offset 0x1C gives the whole 32-bit enable word, and any nonzero value enables the interrupt.
- R9: The match register is write-only. Reads of offset 0x00 and of every unmapped or misaligned offset return zero. Writes to 0x10 and to unmapped offsets change nothing.
- R10: An access with any `bus_be` bit low is ignored. A partial write changes no register, and a partial read returns zero.
- R11: Once set, the status bit stays set through further ticks and through clearing of the enable word, until it is explicitly cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count qualifier fed to the prescaler |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_be | input | 4 | Byte enables; only 4'hF is acted on |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after a read |
| irq | output | 1 | Level interrupt, equal to the status bit |

## Verification
The bench sweeps match values across a small 8-bit counter with a prescale of two. For each value it checks that `irq` is still low one enabled cycle before the predicted tick and high right after it. A comparator that is off by one, or a prescaler with the wrong phase, fails at that edge. A match of zero needs a full wrap, and a match written equal to the current count needs a full period, so a design that fires immediately or compares before incrementing is caught. The bench lines a status-clear write up exactly with a match tick; a design that gives the clear priority loses that interrupt. Disabled matches, nonzero and partial writes, writes to the counter and unmapped offsets are each followed by read-back, which exposes any state they corrupt.

// File: rtl/ostick_pkg.sv
`timescale 1ns/1ps
package ostick_pkg;
  localparam int DATA_W     = 32;
  localparam int OFS_MATCH  = 'h00;
  localparam int OFS_COUNT  = 'h10;
  localparam int OFS_STATUS = 'h14;
  localparam int OFS_IEN    = 'h1C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MATCH,
    SEL_COUNT,
    SEL_STATUS,
    SEL_IEN
  } reg_sel_e;
endpackage

// File: rtl/ostick_prescale.sv
`timescale 1ns/1ps
module ostick_prescale #(
  parameter int PRESCALE = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_en,
  output logic tick
);
  generate
    if (PRESCALE <= 1) begin : g_direct
      assign tick = tick_en;
    end else begin : g_div
      localparam int PW = $clog2(PRESCALE);
      localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
      logic [PW-1:0] phase;
      logic          at_last;

      assign at_last = (phase == LAST);
      assign tick    = tick_en && at_last;

      always_ff @(posedge clk) begin
        if (rst)          phase <= '0;
        else if (tick_en) phase <= at_last ? '0 : phase + 1'b1;
      end

      // R2: phase never leaves its range and holds when not enabled
      a_r2_phase_range: assert property (@(posedge clk) disable iff (rst)
        phase <= LAST);
      a_r2_phase_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(phase));
    end
  endgenerate
endmodule

// File: rtl/ostick_counter.sv
`timescale 1ns/1ps
module ostick_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] match_val,
  output logic [CNT_W-1:0] cnt,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = cnt + 1'b1;
  assign hit     = tick && (cnt_nxt == match_val);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt_nxt;
  end

  // R2: one step per tick, no movement otherwise
  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == $past(cnt) + 1'b1));
  a_r2_count_hold: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));
  // R3: a hit lands the counter on the match value
  a_r3_hit_lands: assert property (@(posedge clk) disable iff (rst)
    hit |=> (cnt == $past(match_val)));
endmodule

// File: rtl/ostick_regs.sv
`timescale 1ns/1ps
module ostick_regs
  import ostick_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              hit,
  output logic [CNT_W-1:0]  match_val,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              status
);
  reg_sel_e          sel;
  logic              acc, wr_acc, rd_acc;
  logic [DATA_W-1:0] ien;
  logic              set_evt, clr_req;
  logic [DATA_W-1:0] rd_mux;

  assign acc    = bus_sel && (bus_be == 4'hF);
  assign wr_acc = acc && bus_wr;
  assign rd_acc = acc && !bus_wr;

  always_comb begin
    if      (bus_addr == ADDR_W'(OFS_MATCH))  sel = SEL_MATCH;
    else if (bus_addr == ADDR_W'(OFS_COUNT))  sel = SEL_COUNT;
    else if (bus_addr == ADDR_W'(OFS_STATUS)) sel = SEL_STATUS;
    else if (bus_addr == ADDR_W'(OFS_IEN))    sel = SEL_IEN;
    else                                      sel = SEL_NONE;
  end

  assign set_evt = hit && (|ien);
  assign clr_req = wr_acc && (sel == SEL_STATUS) && (bus_wdata == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      match_val <= '0;
      ien       <= '0;
    end else if (wr_acc) begin
      if (sel == SEL_MATCH) match_val <= bus_wdata[CNT_W-1:0];
      if (sel == SEL_IEN)   ien       <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          status <= 1'b0;
    else if (set_evt) status <= 1'b1;
    else if (clr_req) status <= 1'b0;
  end

  always_comb begin
    case (sel)
      SEL_COUNT:  rd_mux = DATA_W'(cnt);
      SEL_STATUS: rd_mux = DATA_W'(status);
      SEL_IEN:    rd_mux = ien;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end

  // R3: enabled match raises status
  a_r3_set: assert property (@(posedge clk) disable iff (rst)
    (hit && ien != '0) |=> status);
  // R4: disabled match cannot raise status
  a_r4_no_set_disabled: assert property (@(posedge clk) disable iff (rst)
    (ien == '0 && !status) |=> !status);
  // R5: clear without a competing event drops status
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !(hit && ien != '0)) |=> !status);
  // R6: match wins against a simultaneous clear
  a_r6_match_wins: assert property (@(posedge clk) disable iff (rst)
    (clr_req && hit && ien != '0) |=> status);
  // R10: partial accesses are ignored
  a_r10_partial_rd: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_be != 4'hF) |=> (bus_rdata == '0));
  a_r10_partial_wr: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_be != 4'hF) |=> ($stable(ien) && $stable(match_val)));
  // R11: status is sticky until a clear
  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    (status && !clr_req) |=> status);
endmodule

// File: rtl/ostick_timer.sv
`timescale 1ns/1ps
module ostick_timer
  import ostick_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 32,
  parameter int PRESCALE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  logic             tick;
  logic             hit;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] match_val;
  logic             status;

  ostick_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .tick_en(tick_en), .tick(tick)
  );

  ostick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .match_val(match_val),
    .cnt(cnt), .hit(hit)
  );

  ostick_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .cnt(cnt), .hit(hit), .match_val(match_val),
    .bus_rdata(bus_rdata), .status(status)
  );

  assign irq = status;

  // R1: reset leaves outputs and counter at zero
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (irq == 1'b0 && bus_rdata == '0 && cnt == '0));
endmodule

// File: tb/tb_ostick_timer.sv
`timescale 1ns/1ps
module tb_ostick_timer;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = 8;
  localparam int PS     = 2;
  localparam int RANGE  = 1 << CNT_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              tick_en = 1'b0;
  logic              bus_sel = 1'b0;
  logic              bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [3:0]        bus_be = 4'hF;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  ostick_timer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PRESCALE(PS)) dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  task automatic burst(input int n);
    if (n > 0) begin
      @(negedge clk) tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = 4'hF;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_be = 4'hF;
    d = bus_rdata;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R1: reset state
    check("R1 irq", {31'b0, irq}, 0);
    rd(8'h10, v); check("R1 count", v, 0);
    rd(8'h14, v); check("R1 status", v, 0);
    rd(8'h1C, v); check("R1 ien", v, 0);

    // R2: prescaled counting
    burst(7); rd(8'h10, v); check("R2 count after 7 enables", v, 3);
    burst(1); rd(8'h10, v); check("R2 count after 8 enables", v, 4);

    // R3/R8 sweep of match values, alternating enable words
    for (int m = 0; m < RANGE; m += 15) begin
      int d;
      d = (m == 0) ? RANGE : m;
      do_reset();
      wr(8'h1C, (m % 2) ? 32'h8000_0000 : 32'h1);
      wr(8'h00, m);
      burst(d * PS - 1);
      check("R3 no early event", {31'b0, irq}, 0);
      burst(1);
      check("R3 event on match", {31'b0, irq}, 1);
      rd(8'h10, v); check("R2 R8 count at match", v, m % RANGE);
      rd(8'h14, v); check("R8 status read", v, 1);
      wr(8'h14, 0);
      check("R5 clear drops irq", {31'b0, irq}, 0);
    end

    // R4: disabled match
    do_reset();
    wr(8'h00, 5);
    burst(10);
    check("R4 irq stays low", {31'b0, irq}, 0);
    wr(8'h1C, 1);
    rd(8'h14, v); check("R4 no retroactive set", v, 0);

    // R7: wrap distance and equal re-arm
    do_reset();
    burst(400);
    rd(8'h10, v); check("R2 count 200", v, 200);
    wr(8'h1C, 1); wr(8'h00, 10);
    burst(((10 - 200 + RANGE) % RANGE) * PS - 1);
    check("R7 wrap no early", {31'b0, irq}, 0);
    burst(1);
    check("R7 wrap event", {31'b0, irq}, 1);
    wr(8'h14, 0);
    wr(8'h00, 10);
    burst(RANGE * PS - 1);
    check("R7 equal match no early", {31'b0, irq}, 0);
    burst(1);
    check("R7 equal match full period", {31'b0, irq}, 1);

    // R5: nonzero writes ignored
    wr(8'h14, 1);
    rd(8'h14, v); check("R5 write 1 ignored", v, 1);
    wr(8'h14, 32'h8000_0000);
    rd(8'h14, v); check("R5 write msb ignored", v, 1);
    // R11: sticky through ticks and disable
    wr(8'h1C, 0);
    burst(20);
    check("R11 irq sticky", {31'b0, irq}, 1);
    rd(8'h14, v); check("R11 status sticky", v, 1);
    wr(8'h14, 0);
    rd(8'h14, v); check("R5 clear", v, 0);

    // R6: match and clear in the same cycle
    do_reset();
    wr(8'h1C, 1); wr(8'h00, 3);
    burst(6);
    check("R6 setup event", {31'b0, irq}, 1);
    wr(8'h00, 5);
    @(negedge clk) tick_en = 1'b1;
    repeat (3) @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 0; bus_be = 4'hF;
    @(negedge clk);
    tick_en = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0;
    check("R6 match wins irq", {31'b0, irq}, 1);
    rd(8'h10, v); check("R6 count reached match", v, 5);
    rd(8'h14, v); check("R6 status kept", v, 1);

    // R9: write-only match, counter read-only, unmapped offsets
    do_reset();
    burst(10);
    wr(8'h10, 32'hFF);
    rd(8'h10, v); check("R9 counter write ignored", v, 5);
    wr(8'h00, 32'h33);
    rd(8'h00, v); check("R9 match reads zero", v, 0);
    wr(8'h04, 1); wr(8'h18, 1); wr(8'h20, 1); wr(8'h1D, 1);
    rd(8'h1C, v); check("R9 unmapped writes leave ien", v, 0);
    rd(8'h14, v); check("R9 unmapped writes leave status", v, 0);
    rd(8'h18, v); check("R9 unmapped read", v, 0);
    rd(8'h11, v); check("R9 misaligned read", v, 0);

    // R10/R8: partial accesses and whole-word enable
    wr(8'h1C, 32'hFFFF_FFFF, 4'h1);
    rd(8'h1C, v); check("R10 partial write ignored", v, 0);
    wr(8'h1C, 32'hA5A5_0000);
    rd(8'h1C, v); check("R8 whole enable word", v, 32'hA5A5_0000);
    rd(8'h1C, v, 4'h7); check("R10 partial read zero", v, 0);
    wr(8'h00, 32'h7, 4'hE);
    burst(4);
    check("R10 partial match write ignored", {31'b0, irq}, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule